// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block produces the SCL waveform of an I2C master from the module clock. A prescaler first divides the module clock by a programmable ratio. Each SCL cycle is then built from a driven-low phase and a released phase. The programmed low count and high count set the length of each phase in prescaled cycles, and both phases carry a fixed extra pad that depends on the prescaler setting. With a module clock that the prescaler brings into roughly the 7 to 12 MHz range, the counts map directly onto the bus timing.

The block follows the controller's enable bit. While that bit is low the controller is held in reset: SCL is released, every counter is cleared, and the configuration inputs are captured. Once the bit is high the captured values are frozen and the waveform runs. The released phase counts only after SCL is actually seen high, so a slave holding the line low stretches the clock. A single-cycle tick marks the middle of each high phase so that a sequencing engine can sample SDA there.

Top module: `scl_clk_divider`

## Requirements
- R1: The prescaler ticks once every (psc_cfg + 1) module clocks, and both phase lengths are counted in these ticks. The prescaler restarts at the start of each phase.
- R2: The pad added to each phase is 7 ticks when psc_cfg is 0, 6 ticks when psc_cfg is 1, and 5 ticks when psc_cfg is 2 or more.
- R3: scl_drive_low stays high for exactly (low_cfg + pad) * (psc_cfg + 1) consecutive clocks in every low phase.
- R4: After scl_drive_low falls, the high count starts only once scl_in has been high through the SYNC_STAGES-deep synchronizer. If scl_in first reads high S clocks after the release, the released time is S + SYNC_STAGES + 1 + (high_cfg + pad) * (psc_cfg + 1) clocks.
- R5: bit_mid_tick pulses for one clock per high phase, only while SCL is released. It fires on the prescaler tick that ends high-phase tick number floor((high_cfg + pad) / 2), counted from zero.
- R6: The clock after run is sampled low, scl_drive_low is 0 and all counters are cleared. The next rising edge of run starts a full low phase.
- R7: psc_cfg, low_cfg and high_cfg are captured only while run is low. Changes to them while run is high do not alter the waveform.
- R8: During and right after rst_n, scl_drive_low and bit_mid_tick are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Controller enable; low holds the divider in reset and loads the configuration |
| psc_cfg | input | PSC_W | Prescaler setting; divide ratio is this value plus one |
| low_cfg | input | CNT_W | Low-phase count in prescaled ticks, before the pad |
| high_cfg | input | CNT_W | High-phase count in prescaled ticks, before the pad |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | Request to pull SCL low |
| bit_mid_tick | output | 1 | One-clock pulse in the middle of each high phase |

## Verification
The checker assumes that run is held low through reset, so the configuration is captured before the first phase starts. It also assumes that scl_in is a wired-AND line that cannot read high while the block is pulling it low. The bench builds scl_in from the block's own pull-down and a modelled slave that holds the line low for a set number of clocks after each release. It changes the configuration inputs only while run is low, except in one deliberate case that checks they are ignored. All stimulus is applied between clock edges. Phases are measured only from a fresh rising edge of run, so any phase cut short by dropping run is never compared.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;

   localparam logic [2:0] PAD_DIV1 = 3'd7;
   localparam logic [2:0] PAD_DIV2 = 3'd6;
   localparam logic [2:0] PAD_DIVN = 3'd5;

   // Fixed per-phase pad chosen from the prescaler setting.
   function automatic logic [2:0] pad_for(input logic psc_is_zero, input logic psc_is_one);
      if (psc_is_zero)
         return PAD_DIV1;
      else if (psc_is_one)
         return PAD_DIV2;
      else
         return PAD_DIVN;
   endfunction

endpackage

// File: rtl/scl_div_sync.sv
module scl_div_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain <= '0;
            else if (STAGES == 1)
               chain <= d_in;
            else
               chain <= {chain[STAGES-2:0], d_in};
         end
         assign q_out = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/scl_div_prescale.sv
module scl_div_prescale #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic [PSC_W-1:0] limit,
   output logic             tick,
   output logic [PSC_W-1:0] count
);

   assign tick = run && !hold && (count == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (!run || hold || tick)
         count <= '0;
      else
         count <= count + 1'b1;
   end

endmodule

// File: rtl/scl_div_phase.sv
module scl_div_phase
   import scl_div_pkg::*;
#(
   parameter int LEN_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             bus_high,
   input  logic [LEN_W-1:0] low_len,
   input  logic [LEN_W-1:0] high_len,
   output logic             hold_pre,
   output logic             drive_low,
   output logic             mid_tick
);

   scl_phase_e       phase;
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] low_last;
   logic [LEN_W-1:0] high_last;
   logic [LEN_W-1:0] high_mid;

   assign low_last  = low_len - 1'b1;
   assign high_last = high_len - 1'b1;
   assign high_mid  = high_len >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (!run) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               phase <= PH_LOW;
               cnt   <= '0;
            end
            PH_LOW: begin
               if (tick) begin
                  if (cnt == low_last) begin
                     phase <= PH_WAIT;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            PH_WAIT: begin
               if (bus_high) begin
                  phase <= PH_HIGH;
                  cnt   <= '0;
               end
            end
            default: begin
               if (tick) begin
                  if (cnt == high_last) begin
                     phase <= PH_LOW;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign hold_pre  = (phase == PH_IDLE) || (phase == PH_WAIT);
   assign drive_low = (phase == PH_LOW);
   assign mid_tick  = (phase == PH_HIGH) && tick && (cnt == high_mid);

endmodule

// File: rtl/scl_clk_divider.sv
module scl_clk_divider
   import scl_div_pkg::*;
#(
   parameter int PSC_W       = 8,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] psc_cfg,
   input  logic [CNT_W-1:0] low_cfg,
   input  logic [CNT_W-1:0] high_cfg,
   input  logic             scl_in,
   output logic             scl_drive_low,
   output logic             bit_mid_tick
);

   localparam int LEN_W = CNT_W + 1;

   generate
      if (PSC_W < 1) begin : g_bad_psc
         $error("scl_clk_divider: PSC_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("scl_clk_divider: CNT_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("scl_clk_divider: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   // Configuration captured while held in reset.
   logic [PSC_W-1:0] psc_q;
   logic [LEN_W-1:0] low_len_q;
   logic [LEN_W-1:0] high_len_q;
   logic [2:0]       pad_now;
   logic [LEN_W-1:0] low_len_d;
   logic [LEN_W-1:0] high_len_d;

   assign pad_now    = pad_for(psc_cfg == '0, psc_cfg == PSC_W'(1));
   assign low_len_d  = LEN_W'(low_cfg) + LEN_W'(pad_now);
   assign high_len_d = LEN_W'(high_cfg) + LEN_W'(pad_now);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q      <= '0;
         low_len_q  <= LEN_W'(PAD_DIV1);
         high_len_q <= LEN_W'(PAD_DIV1);
      end else if (!run) begin
         psc_q      <= psc_cfg;
         low_len_q  <= low_len_d;
         high_len_q <= high_len_d;
      end
   end

   logic             bus_high;
   logic             pre_tick;
   logic             pre_hold;
   logic [PSC_W-1:0] pre_cnt;

   scl_div_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (scl_in),
      .q_out (bus_high)
   );

   scl_div_prescale #(
      .PSC_W (PSC_W)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .hold  (pre_hold),
      .limit (psc_q),
      .tick  (pre_tick),
      .count (pre_cnt)
   );

   scl_div_phase #(
      .LEN_W (LEN_W)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (pre_tick),
      .bus_high  (bus_high),
      .low_len   (low_len_q),
      .high_len  (high_len_q),
      .hold_pre  (pre_hold),
      .drive_low (scl_drive_low),
      .mid_tick  (bit_mid_tick)
   );

endmodule

// File: rtl/scl_clk_divider_chk.sv
module scl_clk_divider_chk #(
   parameter int PSC_W = 8,
   parameter int LEN_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             scl_drive_low,
   input logic             bit_mid_tick,
   input logic [PSC_W-1:0] pre_count,
   input logic [PSC_W-1:0] psc_limit,
   input logic [LEN_W-1:0] len_low,
   input logic [LEN_W-1:0] len_high
);

   assert_release_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !scl_drive_low);

   assert_tick_while_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_mid_tick |-> !scl_drive_low);

   assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_mid_tick |=> !bit_mid_tick);

   assert_pre_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pre_count <= psc_limit);

   assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> ($stable(psc_limit) && $stable(len_low) && $stable(len_high)));

   assert_quiet_in_reset_R8: assert property (@(posedge clk)
      !rst_n |-> (!scl_drive_low && !bit_mid_tick));

endmodule

bind scl_clk_divider scl_clk_divider_chk #(
   .PSC_W (PSC_W),
   .LEN_W (LEN_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .run           (run),
   .scl_drive_low (scl_drive_low),
   .bit_mid_tick  (bit_mid_tick),
   .pre_count     (pre_cnt),
   .psc_limit     (psc_q),
   .len_low       (low_len_q),
   .len_high      (high_len_q)
);

// File: tb/scl_clk_divider_tb.sv
module scl_clk_divider_tb;

   localparam int PSC_W = 8;
   localparam int CNT_W = 16;
   localparam int SYNC  = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             run = 1'b0;
   logic [PSC_W-1:0] psc_cfg = '0;
   logic [CNT_W-1:0] low_cfg = '0;
   logic [CNT_W-1:0] high_cfg = '0;
   logic             scl_in;
   logic             scl_drive_low;
   logic             bit_mid_tick;

   always #10 clk = ~clk;

   scl_clk_divider #(
      .PSC_W       (PSC_W),
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .run           (run),
      .psc_cfg       (psc_cfg),
      .low_cfg       (low_cfg),
      .high_cfg      (high_cfg),
      .scl_in        (scl_in),
      .scl_drive_low (scl_drive_low),
      .bit_mid_tick  (bit_mid_tick)
   );

   // Slave model: wired-AND line, held low for 'stretch' clocks after release.
   int rel_cnt = 0;
   int stretch = 0;
   always @(negedge clk) rel_cnt <= scl_drive_low ? 0 : rel_cnt + 1;
   assign scl_in = !scl_drive_low && (rel_cnt > stretch);

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Scoreboard: kind 0 = low length, 1 = mid-tick offset, 2 = released length.
   typedef struct {
      int    kind;
      int    val;
      string req;
   } item_t;
   item_t exp_q[$];

   function automatic int pad_of(input int p);
      return (p == 0) ? 7 : ((p == 1) ? 6 : 5);
   endfunction

   task automatic score(input int kind, input int meas);
      item_t it;
      if (exp_q.size() == 0) return;
      it = exp_q.pop_front();
      check(it.kind == kind && it.val == meas, it.req, meas, it.val);
   endtask

   // Monitor
   bit prev_dl = 0;
   bit seen    = 0;
   int lc      = 0;
   int hc      = 0;
   always @(negedge clk) begin
      if (!run || !rst_n) begin
         prev_dl = 0;
         seen    = 0;
         lc      = 0;
         hc      = 0;
      end else begin
         if (scl_drive_low) begin
            if (!prev_dl && seen) score(2, hc);
            lc = prev_dl ? lc + 1 : 1;
         end else begin
            if (prev_dl) begin
               score(0, lc);
               seen = 1;
               hc   = 1;
            end else begin
               hc = hc + 1;
            end
            if (bit_mid_tick && seen) score(1, hc);
         end
         prev_dl = scl_drive_low;
      end
   end

   // Driver
   task automatic drive_cycle();
      @(posedge clk);
      #2;
   endtask

   task automatic run_cfg(input int p, input int l, input int h, input int s, input int periods,
                          input bit poke, input string tag);
      int pd;
      int pp;
      int hl;
      item_t it;
      drive_cycle();
      run      = 1'b0;
      psc_cfg  = PSC_W'(p);
      low_cfg  = CNT_W'(l);
      high_cfg = CNT_W'(h);
      stretch  = s;
      drive_cycle();
      drive_cycle();
      pd = pad_of(p);
      pp = p + 1;
      hl = h + pd;
      for (int i = 0; i < periods; i++) begin
         it.kind = 0; it.val = (l + pd) * pp;                    it.req = {tag, " R3 low"};  exp_q.push_back(it);
         it.kind = 1; it.val = s + SYNC + 1 + (hl / 2) * pp + p + 1; it.req = {tag, " R5 mid"};  exp_q.push_back(it);
         it.kind = 2; it.val = s + SYNC + 1 + hl * pp;           it.req = {tag, " R4 high"}; exp_q.push_back(it);
      end
      run = 1'b1;
      if (poke) begin
         repeat (3) drive_cycle();
         // R7: these changes while running must have no effect
         psc_cfg  = PSC_W'(p + 3);
         low_cfg  = CNT_W'(l + 9);
         high_cfg = CNT_W'(h + 11);
      end
      while (exp_q.size() > 0) drive_cycle();
      run = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(scl_drive_low == 1'b0, "R6 release", int'(scl_drive_low), 0);
   endtask

   // Watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog R1 actual %0d expected %0d", wd, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: quiet during reset
      check(scl_drive_low == 1'b0, "R8 drive in reset", int'(scl_drive_low), 0);
      check(bit_mid_tick == 1'b0, "R8 tick in reset", int'(bit_mid_tick), 0);
      drive_cycle();
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(scl_drive_low == 1'b0, "R8 drive after reset", int'(scl_drive_low), 0);
      check(bit_mid_tick == 1'b0, "R8 tick after reset", int'(bit_mid_tick), 0);

      run_cfg(0, 4, 4, 0, 2, 1'b0, "R1 R2 psc0");
      run_cfg(1, 3, 6, 0, 2, 1'b0, "R1 R2 psc1");
      run_cfg(2, 5, 2, 0, 2, 1'b0, "R1 R2 psc2");
      run_cfg(3, 0, 0, 0, 2, 1'b0, "R1 R2 psc3 zero counts");
      run_cfg(1, 2, 3, 7, 2, 1'b0, "R4 stretch");
      run_cfg(0, 6, 5, 0, 3, 1'b1, "R7 frozen cfg");

      // R6: drop run in the middle of a low phase, then restart with a full low phase
      drive_cycle();
      psc_cfg  = PSC_W'(2);
      low_cfg  = CNT_W'(8);
      high_cfg = CNT_W'(3);
      stretch  = 0;
      drive_cycle();
      run = 1'b1;
      repeat (6) drive_cycle();
      check(scl_drive_low == 1'b1, "R6 low before drop", int'(scl_drive_low), 1);
      run = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(scl_drive_low == 1'b0, "R6 released after drop", int'(scl_drive_low), 0);
      check(bit_mid_tick == 1'b0, "R6 no tick after drop", int'(bit_mid_tick), 0);
      run_cfg(2, 8, 3, 0, 1, 1'b0, "R6 restart");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule